// File: doc/BRIEF.md
# Linked-List Descriptor DMA Channel

This block is one DMA channel that walks a chain of transfer descriptors kept in memory. Software writes the first descriptor's link, byte count, source, destination and configuration into the channel's register window. Writing the configuration word with its enable bit set starts the transfer. The channel then issues copy beats on a valid/ready beat port until the byte count runs out. If the link word has its chain bit set, the channel fetches the next 8-word descriptor from memory over a request/response read port, loads it and carries on. A link without the chain bit ends the chain. A link that points back to an earlier descriptor forms a ring that never ends.

Both memory-facing interfaces follow valid/ready rules. On the beat port, once `beat_valid` is high it stays high, with `beat_src`, `beat_dst` and `beat_bytes` unchanged, until the cycle in which `beat_ready` is high. That cycle moves the beat. The descriptor request is held the same way until `desc_req_ready` is high. Response words are accepted one per cycle in which both `desc_rsp_valid` and `desc_rsp_ready` are high, and they must arrive in address order. Status pins report busy, the remaining count and the link register. Two one-cycle event pins report a finished descriptor and a finished chain.

Top module: `llx_dma_chan`

## Requirements
- R1: Register window byte offsets: link 0x00, count 0x0C, source 0x14, destination 0x18, configuration 0x1C. Writing the configuration with bit 0 set while the channel is idle starts it, and `busy` is high from the next cycle.
- R2: Each beat moves min(1 << w, remaining) bytes. Here w is configuration bits 15:12, limited to MAXW.
- R3: Configuration bit 31 makes the source address advance by each beat's size, and bit 30 does the same for the destination. An address whose bit is clear stays fixed on every beat.
- R4: `remain` shows the remaining byte count of the running descriptor. It drops by `beat_bytes` on every accepted beat.
- R5: When a descriptor finishes, `node_done` pulses for one cycle if that descriptor's configuration bit 1 is set, and stays low otherwise.
- R6: When a descriptor finishes and link bit 1 is set, the channel requests the 8 words at the link address with bits 4:0 cleared. It then loads word 0 as link, word 4 as count, word 5 as source, word 6 as destination and word 7 as configuration. Words 1 to 3 are ignored.
- R7: When a descriptor finishes and link bit 1 is clear (this includes a link of zero), `chain_done` pulses for one cycle. In that same cycle `busy` goes low and the channel is idle.
- R8: Writing the configuration with bit 0 clear while busy pauses the channel. `busy` goes low, no new beat starts, and a beat already offered is completed. Writing it again with bit 0 set resumes from the remaining count.
- R9: Writes to link, count, source, destination and the non-enable configuration bits are ignored while `busy` is high.
- R10: A beat offered on the beat port stays valid with stable fields until it is accepted.
- R11: A link that points back to an earlier descriptor, with bit 1 set, repeats that ring without ever raising `chain_done`.
- R12: `link_now` reads back the link word of the descriptor being run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_ofs | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| desc_req_valid | output | 1 | Descriptor fetch request valid |
| desc_req_ready | input | 1 | Descriptor fetch request accepted |
| desc_req_addr | output | 32 | Descriptor base address (32-byte aligned) |
| desc_rsp_valid | input | 1 | Descriptor word valid |
| desc_rsp_ready | output | 1 | Channel can take a descriptor word |
| desc_rsp_data | input | 32 | Descriptor word |
| beat_valid | output | 1 | Copy beat offered |
| beat_ready | input | 1 | Copy beat taken |
| beat_src | output | 32 | Beat source address |
| beat_dst | output | 32 | Beat destination address |
| beat_bytes | output | MAXW+1 | Bytes in this beat |
| busy | output | 1 | Channel running and enabled |
| node_done | output | 1 | Descriptor-complete event pulse |
| chain_done | output | 1 | Chain-complete event pulse |
| remain | output | CNT_W | Remaining byte count |
| link_now | output | 32 | Current link register |

## Verification
The assertions assume a few things about the inputs. The environment returns exactly eight response words for each accepted request, in order. A register write arrives in a cycle of its own. The bench stays inside these limits: its memory responder answers one request at a time, with idle cycles between some words, and every register write is a single-cycle strobe. It changes `beat_ready` only between clock edges, and it pauses the channel only while the beat port is stalled, so the number of beats that complete during a pause is known in advance.

// File: rtl/llx_pkg.sv
package llx_pkg;
  localparam int unsigned DESC_WORDS = 8;
  localparam int unsigned W_LINK = 0;
  localparam int unsigned W_CNT  = 4;
  localparam int unsigned W_SRC  = 5;
  localparam int unsigned W_DST  = 6;
  localparam int unsigned W_CFG  = 7;

  localparam logic [5:0] OFS_LINK = 6'h00;
  localparam logic [5:0] OFS_CNT  = 6'h0C;
  localparam logic [5:0] OFS_SRC  = 6'h14;
  localparam logic [5:0] OFS_DST  = 6'h18;
  localparam logic [5:0] OFS_CFG  = 6'h1C;

  localparam int unsigned CFG_EN    = 0;
  localparam int unsigned CFG_NODE  = 1;
  localparam int unsigned CFG_DINC  = 30;
  localparam int unsigned CFG_SINC  = 31;
  localparam int unsigned LINK_CHAIN = 1;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FETCH} chan_st_e;
  typedef enum logic [1:0] {F_IDLE, F_REQ, F_RSP} fetch_st_e;

  typedef struct packed {
    logic [31:0] link;
    logic [31:0] count;
    logic [31:0] src;
    logic [31:0] dst;
    logic [31:0] cfg;
  } desc_t;
endpackage

// File: rtl/llx_fetch.sv
module llx_fetch
  import llx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] base,
  output logic        req_valid,
  input  logic        req_ready,
  output logic [31:0] req_addr,
  input  logic        rsp_valid,
  output logic        rsp_ready,
  input  logic [31:0] rsp_data,
  output logic        done,
  output desc_t       desc
);
  localparam int unsigned IDX_W = $clog2(DESC_WORDS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DESC_WORDS - 1);

  fetch_st_e        fst;
  logic [IDX_W-1:0] idx;
  logic [31:0]      addr_q;

  assign req_valid = (fst == F_REQ);
  assign req_addr  = addr_q;
  assign rsp_ready = (fst == F_RSP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fst    <= F_IDLE;
      idx    <= '0;
      addr_q <= '0;
      done   <= 1'b0;
      desc   <= '0;
    end else begin
      done <= 1'b0;
      case (fst)
        F_IDLE: if (start) begin
          addr_q <= base;
          idx    <= '0;
          fst    <= F_REQ;
        end
        F_REQ: if (req_ready) fst <= F_RSP;
        F_RSP: if (rsp_valid) begin
          if (idx == IDX_W'(W_LINK)) desc.link  <= rsp_data;
          if (idx == IDX_W'(W_CNT))  desc.count <= rsp_data;
          if (idx == IDX_W'(W_SRC))  desc.src   <= rsp_data;
          if (idx == IDX_W'(W_DST))  desc.dst   <= rsp_data;
          if (idx == IDX_W'(W_CFG))  desc.cfg   <= rsp_data;
          if (idx == IDX_LAST) begin
            fst  <= F_IDLE;
            done <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: fst <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/llx_beat.sv
module llx_beat #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned MAXW  = 3,
  localparam int unsigned BYTES_W = MAXW + 1
) (
  input  logic [3:0]         wsel,
  input  logic               sinc,
  input  logic               dinc,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [31:0]        src,
  input  logic [31:0]        dst,
  output logic [BYTES_W-1:0] bytes,
  output logic [31:0]        src_nxt,
  output logic [31:0]        dst_nxt
);
  logic [3:0]         wcl;
  logic [BYTES_W-1:0] size;

  always_comb begin
    wcl   = (wsel > 4'(MAXW)) ? 4'(MAXW) : wsel;
    size  = BYTES_W'(1) << wcl;
    bytes = (cnt < CNT_W'(size)) ? cnt[BYTES_W-1:0] : size;
    src_nxt = sinc ? src + 32'(bytes) : src;
    dst_nxt = dinc ? dst + 32'(bytes) : dst;
  end
endmodule

// File: rtl/llx_dma_chan.sv
module llx_dma_chan
  import llx_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned MAXW  = 3,
  localparam int unsigned BYTES_W = MAXW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [5:0]         reg_ofs,
  input  logic [31:0]        reg_wdata,
  output logic               desc_req_valid,
  input  logic               desc_req_ready,
  output logic [31:0]        desc_req_addr,
  input  logic               desc_rsp_valid,
  output logic               desc_rsp_ready,
  input  logic [31:0]        desc_rsp_data,
  output logic               beat_valid,
  input  logic               beat_ready,
  output logic [31:0]        beat_src,
  output logic [31:0]        beat_dst,
  output logic [BYTES_W-1:0] beat_bytes,
  output logic               busy,
  output logic               node_done,
  output logic               chain_done,
  output logic [CNT_W-1:0]   remain,
  output logic [31:0]        link_now
);
  chan_st_e         st;
  logic [31:0]      link_q, src_q, dst_q, cfg_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_en, hold_q, fstart_q, node_q, chain_q;
  logic             fdone, beat_go, desc_end;
  desc_t            fdesc;
  logic [31:0]      src_nxt, dst_nxt;
  logic             unused_bits;

  assign unused_bits = ^{cfg_q[29:16], cfg_q[11:2], cfg_q[0], fdesc.count, reg_wdata};

  llx_fetch u_fetch (
    .clk, .rst_n,
    .start     (fstart_q),
    .base      ({link_q[31:5], 5'b0}),
    .req_valid (desc_req_valid),
    .req_ready (desc_req_ready),
    .req_addr  (desc_req_addr),
    .rsp_valid (desc_rsp_valid),
    .rsp_ready (desc_rsp_ready),
    .rsp_data  (desc_rsp_data),
    .done      (fdone),
    .desc      (fdesc)
  );

  llx_beat #(.CNT_W(CNT_W), .MAXW(MAXW)) u_beat (
    .wsel    (cfg_q[15:12]),
    .sinc    (cfg_q[CFG_SINC]),
    .dinc    (cfg_q[CFG_DINC]),
    .cnt     (cnt_q),
    .src     (src_q),
    .dst     (dst_q),
    .bytes   (beat_bytes),
    .src_nxt (src_nxt),
    .dst_nxt (dst_nxt)
  );

  // A beat already offered keeps going through a pause until it is taken.
  assign busy       = (st != ST_IDLE) && run_en;
  assign beat_valid = (st == ST_RUN) && (cnt_q != '0) && (run_en || hold_q);
  assign beat_go    = beat_valid && beat_ready;
  assign desc_end   = (st == ST_RUN) && run_en && (cnt_q == '0);

  assign beat_src   = src_q;
  assign beat_dst   = dst_q;
  assign remain     = cnt_q;
  assign link_now   = link_q;
  assign node_done  = node_q;
  assign chain_done = chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      link_q   <= '0;
      cnt_q    <= '0;
      src_q    <= '0;
      dst_q    <= '0;
      cfg_q    <= '0;
      run_en   <= 1'b0;
      hold_q   <= 1'b0;
      fstart_q <= 1'b0;
      node_q   <= 1'b0;
      chain_q  <= 1'b0;
    end else begin
      node_q   <= 1'b0;
      chain_q  <= 1'b0;
      fstart_q <= 1'b0;
      hold_q   <= beat_valid && !beat_ready;

      // software side: full loads only when not busy
      if (reg_we && !busy) begin
        case (reg_ofs)
          OFS_LINK: link_q <= reg_wdata;
          OFS_CNT:  cnt_q  <= reg_wdata[CNT_W-1:0];
          OFS_SRC:  src_q  <= reg_wdata;
          OFS_DST:  dst_q  <= reg_wdata;
          OFS_CFG:  cfg_q  <= reg_wdata;
          default: ;
        endcase
      end
      if (reg_we && reg_ofs == OFS_CFG) begin
        run_en <= reg_wdata[CFG_EN];
        if (reg_wdata[CFG_EN] && st == ST_IDLE) st <= ST_RUN;
      end

      // channel side overrides software in the same cycle
      if (beat_go) begin
        cnt_q <= cnt_q - CNT_W'(beat_bytes);
        src_q <= src_nxt;
        dst_q <= dst_nxt;
      end
      if (desc_end) begin
        node_q <= cfg_q[CFG_NODE];
        if (link_q[LINK_CHAIN]) begin
          st       <= ST_FETCH;
          fstart_q <= 1'b1;
        end else begin
          st      <= ST_IDLE;
          chain_q <= 1'b1;
          run_en  <= 1'b0;
        end
      end
      if (st == ST_FETCH && fdone) begin
        link_q <= fdesc.link;
        cnt_q  <= fdesc.count[CNT_W-1:0];
        src_q  <= fdesc.src;
        dst_q  <= fdesc.dst;
        cfg_q  <= fdesc.cfg;
        st     <= ST_RUN;
      end
    end
  end
endmodule

// File: rtl/llx_dma_chan_chk.sv
module llx_dma_chan_chk #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned MAXW  = 3,
  localparam int unsigned BYTES_W = MAXW + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               desc_req_valid,
  input logic               desc_req_ready,
  input logic [31:0]        desc_req_addr,
  input logic               beat_valid,
  input logic               beat_ready,
  input logic [31:0]        beat_src,
  input logic [31:0]        beat_dst,
  input logic [BYTES_W-1:0] beat_bytes,
  input logic               busy,
  input logic               node_done,
  input logic               chain_done,
  input logic [CNT_W-1:0]   remain
);
  assert_beat_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_src) && $stable(beat_dst)
                                  && $stable(beat_bytes));

  assert_beat_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> beat_bytes != '0 && CNT_W'(beat_bytes) <= remain
                   && CNT_W'(beat_bytes) <= CNT_W'(1 << MAXW));

  assert_remain_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready |=> remain == $past(remain) - CNT_W'($past(beat_bytes)));

  assert_pause_no_new_R8: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !busy |-> $past(beat_valid && !beat_ready));

  assert_chain_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chain_done |-> !busy && !beat_valid);

  assert_node_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    node_done |-> !beat_valid);

  assert_req_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    desc_req_valid |-> desc_req_addr[4:0] == 5'd0);

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    desc_req_valid && !desc_req_ready |=> desc_req_valid && $stable(desc_req_addr));
endmodule

bind llx_dma_chan llx_dma_chan_chk #(.CNT_W(CNT_W), .MAXW(MAXW)) u_chk (
  .clk, .rst_n, .desc_req_valid, .desc_req_ready, .desc_req_addr,
  .beat_valid, .beat_ready, .beat_src, .beat_dst, .beat_bytes,
  .busy, .node_done, .chain_done, .remain
);

// File: tb/llx_dma_chan_test.sv
`timescale 1ns/1ps
module llx_dma_chan_test;
  localparam int CNT_W = 16;
  localparam int MAXW = 3;
  localparam int BYTES_W = MAXW + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [5:0] reg_ofs = '0;
  logic [31:0] reg_wdata = '0;
  logic desc_req_valid, desc_req_ready, desc_rsp_valid, desc_rsp_ready;
  logic [31:0] desc_req_addr, desc_rsp_data;
  logic beat_valid, beat_ready;
  logic [31:0] beat_src, beat_dst;
  logic [BYTES_W-1:0] beat_bytes;
  logic busy, node_done, chain_done;
  logic [CNT_W-1:0] remain;
  logic [31:0] link_now;

  llx_dma_chan #(.CNT_W(CNT_W), .MAXW(MAXW)) uut (.*);

  always #2.5 clk = ~clk;

  typedef struct packed { logic [31:0] s; logic [31:0] d; logic [BYTES_W-1:0] b; } beat_t;
  beat_t exp_q[$];
  logic [31:0] mem [0:63];
  int checks = 0, errors = 0, nodes = 0, chains = 0, beats = 0;
  int ready_mode = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // driver: expected beats for one descriptor
  task automatic push_desc(input logic [31:0] s, input logic [31:0] d,
                           input int cnt, input logic [31:0] cfg);
    int w = int'(cfg[15:12]);
    int sz;
    int b;
    if (w > MAXW) w = MAXW;
    sz = 1 << w;
    while (cnt > 0) begin
      b = (cnt < sz) ? cnt : sz;
      exp_q.push_back('{s: s, d: d, b: BYTES_W'(b)});
      if (cfg[31]) s = s + 32'(b);
      if (cfg[30]) d = d + 32'(b);
      cnt -= b;
    end
  endtask

  task automatic reg_wr(input logic [5:0] ofs, input logic [31:0] data);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_ofs = ofs; reg_wdata = data;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic load_regs(input logic [31:0] lk, input logic [31:0] cnt,
                           input logic [31:0] s, input logic [31:0] d);
    reg_wr(6'h00, lk); reg_wr(6'h0C, cnt); reg_wr(6'h14, s); reg_wr(6'h18, d);
  endtask

  task automatic wait_chains(input int target, input string req);
    int n = 0;
    while (chains < target && n < 20000) begin @(negedge clk); n++; end
    check(chains >= target, req, "chain end reached", 32'(chains), 32'(target));
  endtask

  // beat_ready driver
  initial begin
    beat_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      cyc++;
      case (ready_mode)
        0: beat_ready = 1'b1;
        1: beat_ready = (cyc % 3 != 1);
        default: beat_ready = 1'b0;
      endcase
    end
  end

  // memory responder
  initial begin
    logic [31:0] raddr;
    desc_req_ready = 1'b1;
    desc_rsp_valid = 1'b0;
    desc_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (desc_req_valid) begin
        raddr = desc_req_addr;
        @(posedge clk); #1;
        for (int k = 0; k < 8; k++) begin
          desc_rsp_valid = 1'b1;
          desc_rsp_data  = mem[6'(raddr[7:2] + 6'(k))];
          do @(negedge clk); while (!desc_rsp_ready);
          @(posedge clk); #1;
          desc_rsp_valid = 1'b0;
          if (k % 2 == 1) begin @(posedge clk); #1; end
        end
      end
    end
  end

  // monitor / scoreboard
  initial begin
    beat_t e;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (node_done) nodes++;
        if (chain_done) chains++;
        if (beat_valid && beat_ready) begin
          beats++;
          if (exp_q.size() == 0) begin
            check(1'b0, "R2,R3", "unexpected beat src", beat_src, 32'h0);
          end else begin
            e = exp_q.pop_front();
            check(beat_bytes == e.b, "R2", "beat bytes", 32'(beat_bytes), 32'(e.b));
            check(beat_src == e.s, "R3", "beat src", beat_src, e.s);
            check(beat_dst == e.d, "R3", "beat dst", beat_dst, e.d);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n0, c0, b0;
    for (int i = 0; i < 64; i++) mem[i] = 32'hFFFF_FFFF;
    // chain: B at 0x40, C at 0x60 (link 0x80 without chain bit ends it)
    mem[16] = 32'h0000_0062; mem[20] = 32'd7; mem[21] = 32'h300; mem[22] = 32'h400;
    mem[23] = 32'h4003_3003;
    mem[24] = 32'h0000_0080; mem[28] = 32'd5; mem[29] = 32'h500; mem[30] = 32'h600;
    mem[31] = 32'hC002_2003;
    // ring at 0xA0 pointing to itself
    mem[40] = 32'h0000_00A2; mem[44] = 32'd4; mem[45] = 32'h5000; mem[46] = 32'h6000;
    mem[47] = 32'hC002_2003;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1", "reset busy", 32'(busy), 32'h0);
    check(beat_valid == 1'b0, "R10", "reset beat_valid", 32'(beat_valid), 32'h0);
    check(remain == '0, "R4", "reset remain", 32'(remain), 32'h0);
    check(chain_done == 1'b0, "R7", "reset chain_done", 32'(chain_done), 32'h0);

    // T1: single descriptor, 4-byte beats, short tail, node event
    load_regs(32'h0, 32'd21, 32'h1000, 32'h2000);
    push_desc(32'h1000, 32'h2000, 21, 32'hC002_2003);
    n0 = nodes;
    reg_wr(6'h1C, 32'hC002_2003);
    @(negedge clk);
    check(busy == 1'b1, "R1", "busy after start", 32'(busy), 32'h1);
    check(remain == 16'd21, "R4", "remain after start", 32'(remain), 32'd21);
    wait_chains(1, "R7");
    @(negedge clk);
    check(busy == 1'b0, "R7", "busy after chain end", 32'(busy), 32'h0);
    check(nodes == n0 + 1, "R5", "node events", 32'(nodes), 32'(n0 + 1));
    check(exp_q.size() == 0, "R2", "leftover beats", 32'(exp_q.size()), 32'h0);

    // T2: fixed source, byte beats, no node event, stalling sink
    ready_mode = 1;
    load_regs(32'h0, 32'd3, 32'h10, 32'h20);
    push_desc(32'h10, 32'h20, 3, 32'h4000_0001);
    n0 = nodes;
    reg_wr(6'h1C, 32'h4000_0001);
    wait_chains(2, "R3");
    check(nodes == n0, "R5", "no node event", 32'(nodes), 32'(n0));
    check(exp_q.size() == 0, "R3", "leftover beats", 32'(exp_q.size()), 32'h0);

    // T3: three-descriptor chain through memory
    load_regs(32'h42, 32'd10, 32'h100, 32'h200);
    push_desc(32'h100, 32'h200, 10, 32'hC001_1001);
    push_desc(32'h300, 32'h400, 7, 32'h4003_3003);
    push_desc(32'h500, 32'h600, 5, 32'hC002_2003);
    n0 = nodes;
    reg_wr(6'h1C, 32'hC001_1001);
    wait_chains(3, "R6");
    check(exp_q.size() == 0, "R6", "fetched descriptors all run", 32'(exp_q.size()), 32'h0);
    check(nodes == n0 + 2, "R5", "node events in chain", 32'(nodes), 32'(n0 + 2));
    check(link_now == 32'h80, "R12", "link readback", link_now, 32'h80);
    check(chains == 3, "R7", "nonzero link without chain bit ends", 32'(chains), 32'd3);

    // T4: writes ignored while busy, pause and resume
    ready_mode = 2;
    load_regs(32'h0, 32'd40, 32'h3000, 32'h4000);
    push_desc(32'h3000, 32'h4000, 40, 32'h4000_0001);
    reg_wr(6'h1C, 32'h4000_0001);
    reg_wr(6'h14, 32'hDEAD);
    reg_wr(6'h0C, 32'd2);
    @(negedge clk);
    check(beat_src == 32'h3000, "R9", "src write while busy", beat_src, 32'h3000);
    check(remain == 16'd40, "R9", "count write while busy", 32'(remain), 32'd40);
    reg_wr(6'h1C, 32'h4000_0000);
    @(negedge clk);
    check(busy == 1'b0, "R8", "busy while paused", 32'(busy), 32'h0);
    check(beat_valid == 1'b1, "R10", "offered beat held over pause", 32'(beat_valid), 32'h1);
    b0 = beats;
    ready_mode = 0;
    repeat (6) @(negedge clk);
    check(beats == b0 + 1, "R8", "beats during pause", 32'(beats), 32'(b0 + 1));
    check(remain == 16'd39, "R8", "remain during pause", 32'(remain), 32'd39);
    reg_wr(6'h1C, 32'h4000_0001);
    wait_chains(4, "R8");
    check(exp_q.size() == 0, "R8", "resume finishes count", 32'(exp_q.size()), 32'h0);

    // T5: ring never ends
    load_regs(32'hA2, 32'd4, 32'h5000, 32'h6000);
    for (int i = 0; i < 4; i++) push_desc(32'h5000, 32'h6000, 4, 32'hC002_2003);
    n0 = nodes; c0 = chains;
    reg_wr(6'h1C, 32'hC002_2003);
    begin
      int n = 0;
      while (nodes < n0 + 4 && n < 20000) begin @(negedge clk); n++; end
    end
    ready_mode = 2;
    reg_wr(6'h1C, 32'hC002_2002);
    @(negedge clk);
    check(nodes == n0 + 4, "R11", "ring laps", 32'(nodes), 32'(n0 + 4));
    check(chains == c0, "R11", "no chain end on ring", 32'(chains), 32'(c0));
    check(exp_q.size() == 0, "R11", "ring beats", 32'(exp_q.size()), 32'h0);
    check(link_now == 32'hA2, "R12", "ring link readback", link_now, 32'hA2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule